// File: doc/BRIEF.md
# Peripheral Module Clock Disable

This block decides, for up to sixteen peripheral modules, whether each one receives its clock enable and whether software may reach its registers. Software writes a disable register through a simple write port; a set bit turns the matching module off and holds it in its lowest-power state. A build-time presence mask states which modules exist. A module that is absent is never enabled, and its disable bit can neither be set nor read back as one.

A change to the disable register does not reach the modules at once. It is staged and moves to the effective state on the next instruction-cycle strobe, so both turning a module off and turning it back on wait one instruction cycle. The same effective state also gates the register access path: writes to a disabled module are blocked, and a read from it returns zero with its valid qualifier low.

Top module: `pmod_gate`

## Requirements
- R1: After reset the disable register reads zero and every module present in the mask has its clock enable high.
- R2: mod_clk_en[i] is high exactly when module i is present and its effective disable bit is clear.
- R3: Bits of cfg_wr_data for absent modules are dropped on write, cfg_rd_data shows zero in those positions, and absent modules never get a clock enable.
- R4: A cycle with cfg_wr_en high loads cfg_wr_data (masked by presence) into the disable register, visible on cfg_rd_data after that clock edge; without cfg_wr_en the register holds.
- R5: The effective disable state takes the register's value at a clock edge where icyc_stb is high (the value the register held just before that edge) and holds at all other edges, so a new disable value reaches mod_clk_en only at the first strobe edge after the write edge.
- R6: reg_wr_en[i] equals reg_wr_req[i] while module i is enabled and is low otherwise, so writes to a disabled or absent module have no effect.
- R7: rd_valid is high exactly when rd_req is high and the module numbered rd_sel is enabled; rd_data then carries bits [16*rd_sel+15 : 16*rd_sel] of mod_rd_bus, and is zero whenever rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| icyc_stb | input | 1 | One-cycle pulse marking an instruction-cycle boundary |
| cfg_wr_en | input | 1 | Write strobe for the disable register |
| cfg_wr_data | input | 16 | New disable bits, one per module |
| cfg_rd_data | output | 16 | Current disable register contents |
| mod_clk_en | output | 16 | Clock enable per module |
| reg_wr_req | input | 16 | Register write request per module |
| reg_wr_en | output | 16 | Qualified register write enable per module |
| rd_req | input | 1 | Register read request |
| rd_sel | input | 4 | Module number being read |
| mod_rd_bus | input | 256 | Read data of all modules, 16 bits each, module 0 in the low bits |
| rd_data | output | 16 | Qualified read data |
| rd_valid | output | 1 | Read data valid |

## Verification
The assertions assume icyc_stb, cfg_wr_en and the request inputs are settled at every rising edge and that rd_sel stays below the module count. The stimulus changes all inputs only on falling edges and draws rd_sel from the legal range, while strobes, register writes (including ones that touch absent positions) and requests arrive in irregular mixes, so writes are seen both with and without an intervening strobe.

// File: rtl/pmod_pkg.sv
package pmod_pkg;
   localparam int unsigned MAX_MODS = 16;

   function automatic int unsigned sel_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pmod_ctl_reg.sv
module pmod_ctl_reg #(
   parameter int unsigned      NUM_MODS = 16,
   parameter logic [NUM_MODS-1:0] PRESENT = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [NUM_MODS-1:0] wr_data,
   output logic [NUM_MODS-1:0] dis_q
);
   // Only present positions own a flop; absent ones are tied low.
   for (genvar i = 0; i < NUM_MODS; i++) begin : g_bit
      if (PRESENT[i]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     dis_q[i] <= 1'b0;
            else if (wr_en) dis_q[i] <= wr_data[i];
         end
      end else begin : g_tie
         assign dis_q[i] = 1'b0;
      end
   end

   p_write_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> dis_q == $past(wr_data & PRESENT));
   p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(dis_q));
endmodule

// File: rtl/pmod_sync_stage.sv
module pmod_sync_stage #(
   parameter int unsigned NUM_MODS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stb,
   input  logic [NUM_MODS-1:0] dis_d,
   output logic [NUM_MODS-1:0] eff_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   eff_q <= '0;
      else if (stb) eff_q <= dis_d;
   end

   p_take_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> eff_q == $past(dis_d));
   p_hold_off_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(eff_q));
endmodule

// File: rtl/pmod_access_gate.sv
module pmod_access_gate
   import pmod_pkg::*;
#(
   parameter int unsigned NUM_MODS = 16,
   parameter int unsigned DATA_W   = 16,
   localparam int unsigned SEL_W   = sel_bits(NUM_MODS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_MODS-1:0]        active,
   input  logic [NUM_MODS-1:0]        wr_req,
   output logic [NUM_MODS-1:0]        wr_en,
   input  logic                       rd_req,
   input  logic [SEL_W-1:0]           rd_sel,
   input  logic [NUM_MODS*DATA_W-1:0] rd_bus,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       rd_valid
);
   assign wr_en = wr_req & active;

   logic [NUM_MODS-1:0] hit;
   logic [DATA_W-1:0]   slice [NUM_MODS];

   // AND-OR selection: each slice contributes only when selected and live.
   for (genvar i = 0; i < NUM_MODS; i++) begin : g_slot
      assign hit[i]   = rd_req && (rd_sel == SEL_W'(i)) && active[i];
      assign slice[i] = hit[i] ? rd_bus[i*DATA_W +: DATA_W] : '0;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_MODS; i++) rd_data = rd_data | slice[i];
   end
   assign rd_valid = |hit;

   p_valid_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_req);
   p_zero_when_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> rd_data == '0);
   p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/pmod_gate.sv
module pmod_gate
   import pmod_pkg::*;
#(
   parameter int unsigned         NUM_MODS = 16,
   parameter int unsigned         DATA_W   = 16,
   parameter logic [NUM_MODS-1:0] PRESENT  = 16'hBF7D,
   localparam int unsigned        SEL_W    = sel_bits(NUM_MODS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       icyc_stb,
   input  logic                       cfg_wr_en,
   input  logic [NUM_MODS-1:0]        cfg_wr_data,
   output logic [NUM_MODS-1:0]        cfg_rd_data,
   output logic [NUM_MODS-1:0]        mod_clk_en,
   input  logic [NUM_MODS-1:0]        reg_wr_req,
   output logic [NUM_MODS-1:0]        reg_wr_en,
   input  logic                       rd_req,
   input  logic [SEL_W-1:0]           rd_sel,
   input  logic [NUM_MODS*DATA_W-1:0] mod_rd_bus,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       rd_valid
);
   if (NUM_MODS < 1 || NUM_MODS > MAX_MODS) begin : g_bad_count
      $error("pmod_gate: NUM_MODS out of range");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("pmod_gate: DATA_W must be positive");
   end

   logic [NUM_MODS-1:0] dis_q;
   logic [NUM_MODS-1:0] eff_q;

   pmod_ctl_reg #(.NUM_MODS(NUM_MODS), .PRESENT(PRESENT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
      .wr_data(cfg_wr_data), .dis_q(dis_q)
   );

   pmod_sync_stage #(.NUM_MODS(NUM_MODS)) u_sync (
      .clk(clk), .rst_n(rst_n), .stb(icyc_stb),
      .dis_d(dis_q), .eff_q(eff_q)
   );

   assign cfg_rd_data = dis_q;
   assign mod_clk_en  = ~eff_q & PRESENT;

   pmod_access_gate #(.NUM_MODS(NUM_MODS), .DATA_W(DATA_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .active(mod_clk_en),
      .wr_req(reg_wr_req), .wr_en(reg_wr_en),
      .rd_req(rd_req), .rd_sel(rd_sel), .rd_bus(mod_rd_bus),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   p_absent_never_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_clk_en & ~PRESENT) == '0);
   p_wr_needs_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en & ~mod_clk_en) == '0);
   p_clk_change_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !icyc_stb |=> $stable(mod_clk_en));
endmodule

// File: tb/pmod_gate_bench.sv
module pmod_gate_bench;
   localparam int N  = 16;
   localparam int DW = 16;
   localparam logic [N-1:0] PRES = 16'hBF7D;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic icyc_stb = 1'b0, cfg_wr_en = 1'b0, rd_req = 1'b0;
   logic [N-1:0] cfg_wr_data = '0, reg_wr_req = '0;
   logic [3:0] rd_sel = '0;
   logic [N*DW-1:0] mod_rd_bus = '0;
   logic [N-1:0] cfg_rd_data, mod_clk_en, reg_wr_en;
   logic [DW-1:0] rd_data;
   logic rd_valid;

   int total = 0, bad = 0;
   logic [N-1:0] m_dis = '0, m_eff = '0;

   always #4 clk = ~clk;

   pmod_gate u_pmod_gate (
      .clk(clk), .rst_n(rst_n), .icyc_stb(icyc_stb),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
      .mod_clk_en(mod_clk_en), .reg_wr_req(reg_wr_req), .reg_wr_en(reg_wr_en),
      .rd_req(rd_req), .rd_sel(rd_sel), .mod_rd_bus(mod_rd_bus),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   // Reference model: state moves at the rising edge from the inputs held there.
   always @(posedge clk) begin
      if (rst_n) begin
         if (icyc_stb) m_eff = m_dis;
         if (cfg_wr_en) m_dis = cfg_wr_data & PRES;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [N-1:0] e_clk;
      logic e_val;
      logic [DW-1:0] e_dat;
      e_clk = ~m_eff & PRES;
      e_val = rd_req && e_clk[rd_sel];
      e_dat = e_val ? mod_rd_bus[rd_sel*DW +: DW] : '0;
      chk("R3/R4 cfg_rd_data", 64'(cfg_rd_data), 64'(m_dis));
      chk("R2/R5 mod_clk_en", 64'(mod_clk_en), 64'(e_clk));
      chk("R6 reg_wr_en", 64'(reg_wr_en), 64'(reg_wr_req & e_clk));
      chk("R7 rd_valid", 64'(rd_valid), 64'(e_val));
      chk("R7 rd_data", 64'(rd_data), 64'(e_dat));
   endtask

   task automatic step(input logic stb, input logic we, input logic [N-1:0] wd,
                       input logic [N-1:0] wq, input logic rq, input logic [3:0] sel);
      @(negedge clk);
      icyc_stb = stb; cfg_wr_en = we; cfg_wr_data = wd;
      reg_wr_req = wq; rd_req = rq; rd_sel = sel;
      for (int i = 0; i < N; i++) mod_rd_bus[i*DW +: DW] = DW'($urandom);
      #1;
      compare_all();
   endtask

   initial begin
      #(8 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 reset cfg_rd_data", 64'(cfg_rd_data), 64'(0));
      chk("R1 reset mod_clk_en", 64'(mod_clk_en), 64'(PRES));
      // Write all ones with no strobe: register shows mask only (R3, R4), clocks unchanged (R5).
      step(1'b0, 1'b1, '1, '1, 1'b1, 4'd0);
      step(1'b0, 1'b0, '0, '1, 1'b1, 4'd0);
      chk("R5 no strobe yet", 64'(mod_clk_en), 64'(PRES));
      chk("R3 absent bits zero", 64'(cfg_rd_data), 64'(PRES));
      // Strobe: everything off, writes and reads blocked (R6, R7).
      step(1'b1, 1'b0, '0, '1, 1'b1, 4'd2);
      step(1'b0, 1'b0, '0, '1, 1'b1, 4'd2);
      chk("R5 off after strobe", 64'(mod_clk_en), 64'(0));
      chk("R6 writes blocked", 64'(reg_wr_en), 64'(0));
      chk("R7 read invalid", 64'({rd_valid, rd_data}), 64'(0));
      // Re-enable in one cycle with a coincident strobe: strobe sees old value (R5).
      step(1'b1, 1'b1, '0, '1, 1'b1, 4'd0);
      step(1'b0, 1'b0, '0, '1, 1'b1, 4'd0);
      chk("R5 strobe same edge uses old", 64'(mod_clk_en), 64'(0));
      step(1'b1, 1'b0, '0, '1, 1'b1, 4'd0);
      step(1'b0, 1'b0, '0, '1, 1'b1, 4'd1);
      chk("R2 back on", 64'(mod_clk_en), 64'(PRES));
      chk("R7 absent read invalid", 64'(rd_valid), 64'(0));
      // Irregular mix.
      for (int c = 0; c < 4000; c++) begin
         step(($urandom % 4) == 0, ($urandom % 5) == 0, N'($urandom), N'($urandom),
              ($urandom % 2) == 0, 4'($urandom));
      end
      // Reset in the middle of activity restores R1.
      @(negedge clk); rst_n = 1'b0; m_dis = '0; m_eff = '0;
      #1;
      chk("R1 mid reset cfg_rd_data", 64'(cfg_rd_data), 64'(0));
      chk("R1 mid reset mod_clk_en", 64'(mod_clk_en), 64'(PRES));
      @(negedge clk); rst_n = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule